// File: doc/BRIEF.md
# Configurable Orthogonal Latin Square Check-Bit Encoder

This block computes the check bits of an orthogonal Latin square error-correcting code for a data word of M×M bits, then keeps only the parity rows that the current configuration enables. Before a memory array goes into service, a test finds its weak cells and a row-enable mask is chosen to suit them. The encoder stores that mask, computes all 2·T·M parity rows for every accepted word, and packs the enabled ones into a narrower check field for the array to store. It also reports how many positions of that field are in use.

The data word is treated as an M×M grid with bit index r·M+c for grid row r and column c. The parity rows fall into 2·T groups of M rows each, and row i of group g has global index g·M+i. Group 0 covers the cells of grid row i. Group 1 covers the cells of grid column i. Each group g ≥ 2 covers the cells for which (r + (g−1)·c) mod M equals i. With M prime, each data bit then lies in exactly 2·T rows, and no two of those rows share any other data bit.

Input words arrive on a valid/ready handshake. The packed result comes out of a single register stage one cycle later. A mask write is refused if it arrives while a word is being offered, and also if the mask would need more stored bits than the field holds.

Top module: `ols_check_encoder`

## Requirements
- R1: Parity row g·M+i (grid index g, index i) is the XOR of the data bits r·M+c that it covers. Group 0 covers the cells with r == i, group 1 covers the cells with c == i, and group g ≥ 2 covers the cells with (r + (g−1)·c) mod M == i.
- R2: Inverting one data bit inverts exactly those stored check bits that come from enabled rows covering that bit. There are at most 2·T of them.
- R3: Enabled parity rows are packed in ascending global row index order. The lowest enabled row goes to out_check bit 0, the next enabled row to bit 1, and so on.
- R4: Every out_check bit at a position equal to or above out_count is zero.
- R5: out_count equals the number of ones in the row-enable mask that was in force when the word was accepted.
- R6: A word is accepted on a clock edge where in_valid and in_ready are both high. out_valid is high in exactly the cycle that follows an accepted word. Words accepted on consecutive cycles give results on consecutive cycles. in_ready is high in every cycle after reset.
- R7: A mask write (cfg_we high) is ignored when in_valid is high in the same cycle.
- R8: A mask write whose mask has more than STORE_W ones is ignored. A mask with exactly STORE_W ones is taken.
- R9: While reset is held, and after reset, out_valid, out_check and out_count are zero. in_ready is low during reset. The mask resets to the lowest STORE_W rows enabled.
- R10: In a cycle that follows no accepted word, out_valid is low and out_check and out_count keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Encoder able to accept |
| in_data | input | M·M (25) | Data word, bit r·M+c |
| cfg_we | input | 1 | Row-enable mask write strobe |
| cfg_mask | input | 2·T·M (20) | Row-enable mask, bit k enables global row k |
| out_valid | output | 1 | Packed check field valid |
| out_check | output | STORE_W (16) | Packed check bits of enabled rows |
| out_count | output | clog2(2·T·M+1) (5) | Number of enabled rows |

## Verification
Parity, packing and count all come out of the same register stage. Each of them is therefore due in the cycle after the edge that accepts the word. The bench drives inputs on the falling edge, and it compares the outputs at the next falling edge, half a cycle after the accepting edge. In streamed runs, the result of word n is compared at the falling edge where word n+1 is driven. A mask write takes effect on its own clock edge, and its effect is observed through the count and packing of the next accepted word. Hold behaviour is checked on idle cycles, and the reference is a bench model of the grid rules and the packing.

// File: rtl/ols_enc_pkg.sv
package ols_enc_pkg;

  // Membership of grid cell (r,c) in row idx of parity group grp, for an m x m grid.
  function automatic bit cell_in_row(int m, int grp, int idx, int r, int c);
    case (grp)
      0:       return (r == idx);
      1:       return (c == idx);
      default: return (((r + (grp - 1) * c) % m) == idx);
    endcase
  endfunction

endpackage

// File: rtl/ols_parity_bank.sv
module ols_parity_bank
  import ols_enc_pkg::*;
#(
  parameter int M = 5,
  parameter int T = 2,
  localparam int DW = M * M,
  localparam int NR = 2 * T * M
) (
  input  logic [DW-1:0] data_i,
  output logic [NR-1:0] par_o
);

  // Cell set covered by one global parity row.
  function automatic logic [DW-1:0] row_cells(int row);
    logic [DW-1:0] v;
    v = '0;
    for (int r = 0; r < M; r++) begin
      for (int c = 0; c < M; c++) begin
        v[r*M+c] = cell_in_row(M, row / M, row % M, r, c);
      end
    end
    return v;
  endfunction

  for (genvar k = 0; k < NR; k++) begin : g_row
    localparam logic [DW-1:0] CELLS = row_cells(k);
    assign par_o[k] = ^(data_i & CELLS);
  end

endmodule

// File: rtl/ols_compactor.sv
module ols_compactor #(
  parameter int NR = 20,
  parameter int SW = 16,
  parameter int CW = 5
) (
  input  logic [NR-1:0] par_i,
  input  logic [NR-1:0] en_i,
  output logic [SW-1:0] pack_o,
  output logic [CW-1:0] cnt_o
);

  int unsigned seen;

  // Running prefix count of enabled rows selects each row's packed slot.
  always_comb begin
    pack_o = '0;
    seen   = 0;
    for (int k = 0; k < NR; k++) begin
      if (en_i[k]) begin
        for (int j = 0; j < SW; j++) begin
          if (seen == j) pack_o[j] = par_i[k];
        end
        seen = seen + 1;
      end
    end
    cnt_o = CW'(seen);
  end

endmodule

// File: rtl/ols_row_config.sv
module ols_row_config #(
  parameter int NR = 20,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [NR-1:0] mask_i,
  input  logic          busy_i,
  output logic [NR-1:0] mask_o
);

  function automatic logic [NR-1:0] low_ones(int n);
    logic [NR-1:0] v;
    v = '0;
    for (int k = 0; k < NR; k++) v[k] = (k < n);
    return v;
  endfunction

  localparam logic [NR-1:0] RST_MASK = low_ones(SW);

  logic          fits;
  logic [NR-1:0] mask_q;

  assign fits = ($countones(mask_i) <= SW);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= RST_MASK;
    end else if (we_i && !busy_i && fits) begin
      mask_q <= mask_i;
    end
  end

  assign mask_o = mask_q;

  // R7: write refused while a word is offered
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (we_i && busy_i) |=> $stable(mask_q));

  // R8: write with too many rows refused
  p_overfull_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (we_i && ($countones(mask_i) > SW)) |=> $stable(mask_q));

  // R8: the stored mask always fits the packed field
  p_mask_fits_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_q) <= SW);

endmodule

// File: rtl/ols_check_encoder.sv
module ols_check_encoder #(
  parameter int M       = 5,
  parameter int T       = 2,
  parameter int STORE_W = 16,
  localparam int DW     = M * M,
  localparam int NR     = 2 * T * M,
  localparam int CW     = $clog2(NR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_data,
  input  logic               cfg_we,
  input  logic [NR-1:0]      cfg_mask,
  output logic               out_valid,
  output logic [STORE_W-1:0] out_check,
  output logic [CW-1:0]      out_count
);

  logic               ready_q;
  logic               accept;
  logic [NR-1:0]      row_en;
  logic [NR-1:0]      par;
  logic [STORE_W-1:0] packed_bits;
  logic [CW-1:0]      packed_cnt;
  logic               valid_q;
  logic [STORE_W-1:0] check_q;
  logic [CW-1:0]      count_q;

  initial begin
    if (STORE_W > NR) $error("STORE_W must not exceed the number of parity rows");
  end

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  ols_row_config #(.NR(NR), .SW(STORE_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we_i   (cfg_we),
    .mask_i (cfg_mask),
    .busy_i (in_valid),
    .mask_o (row_en)
  );

  ols_parity_bank #(.M(M), .T(T)) u_par (
    .data_i (in_data),
    .par_o  (par)
  );

  ols_compactor #(.NR(NR), .SW(STORE_W), .CW(CW)) u_pack (
    .par_i  (par),
    .en_i   (row_en),
    .pack_o (packed_bits),
    .cnt_o  (packed_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      check_q <= '0;
      count_q <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        check_q <= packed_bits;
        count_q <= packed_cnt;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_check = check_q;
  assign out_count = count_q;

  // R6: result follows an accepted word by exactly one cycle
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(accept));

  // R10: outputs hold when nothing was accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_check) && $stable(out_count)));

  // R4: no set bit at or above the used count
  p_high_zero_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_check >> out_count) == '0));

  // R5: the count never exceeds the field width
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    out_count <= CW'(STORE_W));

endmodule

// File: tb/ols_check_encoder_tb.sv
module ols_check_encoder_tb;

  localparam int M       = 5;
  localparam int T       = 2;
  localparam int STORE_W = 16;
  localparam int DW      = M * M;
  localparam int NR      = 2 * T * M;
  localparam int CW      = $clog2(NR + 1);
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic               in_ready;
  logic [DW-1:0]      in_data;
  logic               cfg_we;
  logic [NR-1:0]      cfg_mask;
  logic               out_valid;
  logic [STORE_W-1:0] out_check;
  logic [CW-1:0]      out_count;

  int checks = 0;
  int errors = 0;
  logic [NR-1:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ols_check_encoder #(.M(M), .T(T), .STORE_W(STORE_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .cfg_we    (cfg_we),
    .cfg_mask  (cfg_mask),
    .out_valid (out_valid),
    .out_check (out_check),
    .out_count (out_count)
  );

  function automatic logic [NR-1:0] model_par(logic [DW-1:0] d);
    logic [NR-1:0] p;
    p = '0;
    for (int g = 0; g < 2*T; g++)
      for (int i = 0; i < M; i++)
        for (int r = 0; r < M; r++)
          for (int c = 0; c < M; c++) begin
            bit in;
            if (g == 0)      in = (r == i);
            else if (g == 1) in = (c == i);
            else             in = (((r + (g-1)*c) % M) == i);
            if (in) p[g*M+i] = p[g*M+i] ^ d[r*M+c];
          end
    return p;
  endfunction

  function automatic logic [STORE_W-1:0] model_pack(logic [NR-1:0] p, logic [NR-1:0] en);
    logic [STORE_W-1:0] v;
    int pos;
    v = '0;
    pos = 0;
    for (int k = 0; k < NR; k++) begin
      if (en[k]) begin
        if (pos < STORE_W) v[pos] = p[k];
        pos++;
      end
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_result(logic [DW-1:0] d, logic [NR-1:0] en, string req);
    logic [STORE_W-1:0] ec;
    ec = model_pack(model_par(d), en);
    chk(out_valid == 1'b1, {req, " R6 out_valid"}, 32'(out_valid), 32'd1);
    chk(out_check == ec, {req, " R1 R3 out_check"}, 32'(out_check), 32'(ec));
    chk(out_count == CW'($countones(en)), {req, " R5 out_count"}, 32'(out_count), 32'($countones(en)));
  endtask

  // One word: drive at falling edge, accept at rising edge, check at the next falling edge.
  task automatic send(logic [DW-1:0] d, string req);
    logic [NR-1:0] en;
    en = m_mask;
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(d, en, req);
  endtask

  task automatic write_cfg(logic [NR-1:0] msk, bit with_valid);
    cfg_we   = 1'b1;
    cfg_mask = msk;
    in_valid = with_valid;
    if (!with_valid && $countones(msk) <= STORE_W) m_mask = msk;
    @(negedge clk);
    cfg_we   = 1'b0;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] base;
    logic [STORE_W-1:0] prev;
    logic [DW-1:0] sd [6];
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_data = '0; cfg_we = 1'b0; cfg_mask = '0;
    m_mask = NR'((1 << STORE_W) - 1);
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    chk(in_ready == 1'b0, "R9 in_ready in reset", 32'(in_ready), 0);
    chk(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 0);
    chk(out_check == '0 && out_count == '0, "R9 outputs in reset", 32'(out_check), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 in_ready after reset", 32'(in_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 0);

    // R9 default mask, R1 basic patterns
    send('0, "R9 zero word");
    send({DW{1'b1}}, "R1 all ones");
    send(DW'(25'h0AAAAAA), "R1 alternating");

    // R10: idle cycles keep outputs
    prev = out_check;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid idle", 32'(out_valid), 0);
    chk(out_check == prev, "R10 out_check hold", 32'(out_check), 32'(prev));
    chk(out_count == CW'(STORE_W), "R10 out_count hold", 32'(out_count), STORE_W);

    // R2: single-bit flips, default mask and full-group mask
    base = DW'($urandom);
    send(base, "R2 base");
    prev = out_check;
    for (int b = 0; b < DW; b += 3) begin
      send(base ^ (DW'(1) << b), "R2 flip");
      chk($countones(out_check ^ prev) <= 2*T, "R2 at most 2T bits change",
          32'($countones(out_check ^ prev)), 2*T);
    end

    // R3/R4: only grid-column group enabled
    write_cfg(NR'(20'h003E0), 1'b0);
    send(DW'($urandom), "R3 column group");
    chk(out_check[STORE_W-1:5] == '0, "R4 high zero", 32'(out_check), 0);
    // R3: sparse high rows
    write_cfg(NR'(20'hA0041), 1'b0);
    send(DW'($urandom), "R3 sparse");
    chk(out_check[STORE_W-1:4] == '0, "R4 high zero sparse", 32'(out_check), 0);
    write_cfg('0, 1'b0);
    send(DW'($urandom), "R4 empty mask");

    // R7: write while in_valid high is ignored (mask stays empty)
    in_data = DW'($urandom);
    write_cfg(NR'(20'h0FFFF), 1'b1);
    @(negedge clk);
    send(DW'($urandom), "R7 busy write ignored");
    chk(out_count == '0, "R7 count unchanged", 32'(out_count), 0);

    // R8: 17 ones refused, 16 ones taken
    write_cfg(NR'(20'h1FFFF), 1'b0);
    send(DW'($urandom), "R8 overfull ignored");
    chk(out_count == '0, "R8 overfull count", 32'(out_count), 0);
    write_cfg(NR'(20'hFFFF0), 1'b0);
    send(DW'($urandom), "R8 exactly full");
    chk(out_count == CW'(STORE_W), "R8 full count", 32'(out_count), STORE_W);

    // R6: back-to-back stream
    for (int n = 0; n < 6; n++) sd[n] = DW'($urandom);
    in_valid = 1'b1;
    in_data  = sd[0];
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      check_result(sd[n-1], m_mask, "R6 stream");
      if (n < 6) in_data = sd[n];
      else       in_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 stream end", 32'(out_valid), 0);

    // Random mix of mask writes and words
    for (int n = 0; n < 300; n++) begin
      if (($urandom % 8) == 0) write_cfg(NR'($urandom), ($urandom % 4) == 0);
      send(DW'($urandom), "R1 R3 random");
      if (($urandom % 3) == 0) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule